// File: doc/BRIEF.md
# Invalidation Queue Consumer

This block is the hardware end of a queued invalidation scheme. Software places 16-byte descriptors in a circular ring in memory. The ring's base address and size exponent are held in a queue-address register. Software then moves a tail register forward. While the engine is enabled and its head pointer differs from the tail, it reads the descriptor at the head, checks the type code, acts on the descriptor and moves the head forward by one entry. The head wraps to zero after the last entry.

Context-cache, IOTLB, device-IOTLB and interrupt-entry-cache descriptors are passed whole to the invalidation logic through a valid/ready port. The invalidation effects themselves are outside this block. A wait descriptor can write a 32-bit status word to memory, can hold back later fetches until every status write has been acknowledged, and can raise a one-cycle completion pulse. A descriptor with an unknown type stops the engine. The engine then raises a sticky fault and leaves the head on the bad entry so that software can inspect it.

Top module: `inval_queue_engine`

## Requirements
- R1: Each fetch reads one 128-bit entry at address base + head index × 16. The low word is bits 63:0 and the high word is bits 127:64. The read request holds its address until it is accepted.
- R2: The ring holds 2^(qs+8) entries, where qs is a 3-bit field with values 0..7. The head moves by exactly one entry per consumed descriptor and wraps from the last entry to 0.
- R3: The head output and the tail register hold the entry index in bits 18:4. A fetch starts only when the engine is enabled and the head differs from the tail.
- R4: Type codes (bits 3:0 of the low word) 1 to 4 are presented unchanged on the handoff port. The head advances on the edge where the handoff is accepted. The descriptor is held stable while the port is not ready.
- R5: A type of 0 or 6..15 sets the fault flag and hands nothing off. The head stays on the offending entry, and no further fetch is made while the fault is set.
- R6: The fault flag is sticky. Only a write with bit 0 set to the status register (select 3) clears it.
- R7: A wait descriptor (type 5) with bit 5 set writes low-word bits 63:32 to the dword address in high-word bits 47:2. This happens after every earlier descriptor has been consumed.
- R8: For a wait descriptor with bit 6 (fence) set, the head does not advance and no later entry is fetched until every accepted status write has reported done.
- R9: For a wait descriptor with bit 4 set, the completion output pulses for exactly the one cycle in which the head first shows the advanced value. There is no pulse at any other time.
- R10: After reset the head is 0, the fault flag is clear and no request is active. A write to the queue-address register (select 0: base in bits 47:12, qs in bits 2:0) is ignored while the engine is enabled (select 2, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 queue address, 1 tail, 2 control, 3 status |
| regWdata | input | 64 | Register write data |
| headOfs | output | 19 | Head entry index shifted left by 4 |
| faultFlag | output | 1 | Sticky invalid-descriptor fault |
| memRdReq | output | 1 | Descriptor read request |
| memRdAddr | output | ADDR_W | Descriptor read byte address |
| memRdReady | input | 1 | Read request accepted |
| memRdRspValid | input | 1 | Read data valid |
| memRdRspData | input | 128 | Read data (one entry) |
| memWrValid | output | 1 | Status write request |
| memWrAddr | output | ADDR_W | Status write byte address |
| memWrData | output | 32 | Status write data |
| memWrReady | input | 1 | Status write accepted |
| memWrDone | input | 1 | One earlier accepted status write has completed |
| invValid | output | 1 | Descriptor handoff valid |
| invDesc | output | 128 | Descriptor handed off |
| invReady | input | 1 | Handoff accepted |
| cplPulse | output | 1 | Wait-completion pulse |

## Verification
A tail register write and a head advance can fall in the same cycle. In that cycle the ring both gains an entry and loses one. The bench provokes this by writing the tail one entry at a time while the engine drains the ring. With random ready patterns, many of these writes land on the edge where the head moves. The test passes if every descriptor is consumed exactly once and in order, the head steps by one with wrap-around, and the head finally equals the tail after more than one full lap of the ring.

// File: rtl/iqe_pkg.sv
package iqe_pkg;
  // entry index range carried in a head/tail offset register
  localparam int IDX_W   = 15;
  localparam int OFS_LSB = 4;
  localparam int OFS_W   = IDX_W + OFS_LSB;
  localparam int DESC_W  = 128;

  localparam logic [3:0] DT_CTX    = 4'd1;
  localparam logic [3:0] DT_IOTLB  = 4'd2;
  localparam logic [3:0] DT_DEVTLB = 4'd3;
  localparam logic [3:0] DT_IEC    = 4'd4;
  localparam logic [3:0] DT_WAIT   = 4'd5;

  localparam logic [1:0] RS_QADDR = 2'd0;
  localparam logic [1:0] RS_TAIL  = 2'd1;
  localparam logic [1:0] RS_CTRL  = 2'd2;
  localparam logic [1:0] RS_STAT  = 2'd3;

  typedef struct packed {
    logic latchDesc;
    logic advHead;
    logic setFault;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDREQ, ST_RDWAIT, ST_DECODE, ST_HAND, ST_WRREQ, ST_FENCE
  } state_e;

  function automatic logic isHandoffType(input logic [3:0] t);
    return (t >= DT_CTX) && (t <= DT_IEC);
  endfunction
endpackage

// File: rtl/iqe_datapath.sv
module iqe_datapath
  import iqe_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [63:0]       regWdata,
  input  strobe_t           strb,
  input  logic [DESC_W-1:0] memRdRspData,
  output logic              canFetch,
  output logic [3:0]        descType,
  output logic              waitIrq,
  output logic              waitSw,
  output logic              waitFence,
  output logic              faultFlag,
  output logic [OFS_W-1:0]  headOfs,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [DESC_W-1:0] invDesc
);
  localparam int BASE_W = ADDR_W - 12;

  logic [BASE_W-1:0] baseReg;
  logic [2:0]        qsReg;
  logic              enReg;
  logic              faultReg;
  logic [IDX_W-1:0]  headIdx, tailIdx, sizeMask, headEff, tailEff;
  logic [DESC_W-1:0] descReg;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata;

  // qs = 7 overflows the shift to zero, which still yields an all-ones mask
  assign sizeMask = (IDX_W'(1) << (4'(qsReg) + 4'd8)) - IDX_W'(1);
  assign headEff  = headIdx & sizeMask;
  assign tailEff  = tailIdx & sizeMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseReg  <= '0;
      qsReg    <= '0;
      enReg    <= 1'b0;
      faultReg <= 1'b0;
      headIdx  <= '0;
      tailIdx  <= '0;
      descReg  <= '0;
    end else begin
      if (regWe) begin
        case (regSel)
          RS_QADDR: if (!enReg) begin
            baseReg <= regWdata[ADDR_W-1:12];
            qsReg   <= regWdata[2:0];
          end
          RS_TAIL: tailIdx <= regWdata[OFS_W-1:OFS_LSB];
          RS_CTRL: enReg   <= regWdata[0];
          default: ;
        endcase
      end
      if (strb.setFault)
        faultReg <= 1'b1;
      else if (regWe && regSel == RS_STAT && regWdata[0])
        faultReg <= 1'b0;
      if (strb.advHead)   headIdx <= (headEff + IDX_W'(1)) & sizeMask;
      if (strb.latchDesc) descReg <= memRdRspData;
    end
  end

  assign canFetch  = enReg && !faultReg && (headEff != tailEff);
  assign faultFlag = faultReg;
  assign headOfs   = {headEff, 4'b0000};
  assign memRdAddr = {baseReg, 12'h000} + ADDR_W'({headEff, 4'b0000});
  assign descType  = descReg[3:0];
  assign waitIrq   = descReg[4];
  assign waitSw    = descReg[5];
  assign waitFence = descReg[6];
  assign memWrData = descReg[63:32];
  assign memWrAddr = {descReg[64+ADDR_W-1:66], 2'b00};
  assign invDesc   = descReg;
endmodule

// File: rtl/iqe_ctrl.sv
module iqe_ctrl
  import iqe_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       canFetch,
  input  logic [3:0] descType,
  input  logic       waitIrq,
  input  logic       waitSw,
  input  logic       waitFence,
  input  logic       memRdReady,
  input  logic       memRdRspValid,
  input  logic       memWrReady,
  input  logic       memWrDone,
  input  logic       invReady,
  output strobe_t    strb,
  output logic       memRdReq,
  output logic       memWrValid,
  output logic       invValid,
  output logic       cplPulse
);
  state_e            state, nextState;
  logic [PEND_W-1:0] pendCnt;
  logic              pendFull, wrAcc, waitDone;

  assign pendFull   = &pendCnt;
  assign memWrValid = (state == ST_WRREQ) && !pendFull;
  assign wrAcc      = memWrValid && memWrReady;
  assign memRdReq   = (state == ST_RDREQ);
  assign invValid   = (state == ST_HAND);

  always_comb begin
    nextState = state;
    strb      = '0;
    waitDone  = 1'b0;
    case (state)
      ST_IDLE:   if (canFetch) nextState = ST_RDREQ;
      ST_RDREQ:  if (memRdReady) nextState = ST_RDWAIT;
      ST_RDWAIT: if (memRdRspValid) begin
        strb.latchDesc = 1'b1;
        nextState      = ST_DECODE;
      end
      ST_DECODE: begin
        if (isHandoffType(descType)) begin
          nextState = ST_HAND;
        end else if (descType == DT_WAIT) begin
          if (waitSw)         nextState = ST_WRREQ;
          else if (waitFence) nextState = ST_FENCE;
          else begin
            waitDone  = 1'b1;
            nextState = ST_IDLE;
          end
        end else begin
          strb.setFault = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_HAND: if (invReady) begin
        strb.advHead = 1'b1;
        nextState    = ST_IDLE;
      end
      ST_WRREQ: if (wrAcc) begin
        if (waitFence) nextState = ST_FENCE;
        else begin
          waitDone  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_FENCE: if (pendCnt == '0) begin
        waitDone  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    if (waitDone) strb.advHead = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pendCnt  <= '0;
      cplPulse <= 1'b0;
    end else begin
      state    <= nextState;
      cplPulse <= waitDone && waitIrq;
      if (wrAcc && !memWrDone)
        pendCnt <= pendCnt + PEND_W'(1);
      else if (!wrAcc && memWrDone && pendCnt != '0)
        pendCnt <= pendCnt - PEND_W'(1);
    end
  end
endmodule

// File: rtl/inval_queue_engine.sv
module inval_queue_engine
  import iqe_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [63:0]       regWdata,
  output logic [18:0]       headOfs,
  output logic              faultFlag,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdReady,
  input  logic              memRdRspValid,
  input  logic [127:0]      memRdRspData,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  input  logic              memWrReady,
  input  logic              memWrDone,
  output logic              invValid,
  output logic [127:0]      invDesc,
  input  logic              invReady,
  output logic              cplPulse
);
  strobe_t    strb;
  logic       canFetch, waitIrq, waitSw, waitFence;
  logic [3:0] descType;

  iqe_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .strb(strb), .memRdRspData(memRdRspData), .canFetch(canFetch),
    .descType(descType), .waitIrq(waitIrq), .waitSw(waitSw), .waitFence(waitFence),
    .faultFlag(faultFlag), .headOfs(headOfs), .memRdAddr(memRdAddr),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .invDesc(invDesc)
  );

  iqe_ctrl #(.PEND_W(PEND_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .canFetch(canFetch), .descType(descType),
    .waitIrq(waitIrq), .waitSw(waitSw), .waitFence(waitFence),
    .memRdReady(memRdReady), .memRdRspValid(memRdRspValid),
    .memWrReady(memWrReady), .memWrDone(memWrDone), .invReady(invReady),
    .strb(strb), .memRdReq(memRdReq), .memWrValid(memWrValid),
    .invValid(invValid), .cplPulse(cplPulse)
  );
endmodule

// File: rtl/iqe_chk.sv
module iqe_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic [18:0]       headOfs,
  input logic              faultFlag,
  input logic              memRdReq,
  input logic              memRdReady,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memWrValid,
  input logic              memWrReady,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [31:0]       memWrData,
  input logic              invValid,
  input logic              invReady,
  input logic [127:0]      invDesc,
  input logic              cplPulse
);
  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdReq && !memRdReady |=> memRdReq && $stable(memRdAddr));

  // R2
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    headOfs != $past(headOfs) |-> (headOfs == $past(headOfs) + 19'h10) || (headOfs == 19'h0));

  // R4
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invValid && !invReady |=> invValid && $stable(invDesc));

  // R4
  inv_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invValid |-> (invDesc[3:0] >= 4'd1) && (invDesc[3:0] <= 4'd4));

  // R5
  fault_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    faultFlag |-> !memRdReq);

  // R5
  fault_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    faultFlag && $past(faultFlag) |-> $stable(headOfs));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWrValid && !memWrReady |=> memWrValid && $stable(memWrAddr) && $stable(memWrData));

  // R9
  pulse_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cplPulse |-> headOfs != $past(headOfs));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cplPulse |=> !cplPulse);
endmodule

bind inval_queue_engine iqe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .headOfs(headOfs), .faultFlag(faultFlag),
  .memRdReq(memRdReq), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
  .memWrValid(memWrValid), .memWrReady(memWrReady), .memWrAddr(memWrAddr),
  .memWrData(memWrData), .invValid(invValid), .invReady(invReady),
  .invDesc(invDesc), .cplPulse(cplPulse)
);

// File: tb/inval_queue_engine_tb.sv
`timescale 1ns/1ps
module inval_queue_engine_tb;
  localparam int ADDR_W = 48;
  localparam int QN     = 256;
  localparam logic [47:0] BASE = 48'h0000_1234_5000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              regWe = 1'b0;
  logic [1:0]        regSel = 2'd0;
  logic [63:0]       regWdata = '0;
  logic [18:0]       headOfs;
  logic              faultFlag, memRdReq, memWrValid, invValid, cplPulse;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic              memRdReady = 1'b0, memRdRspValid = 1'b0;
  logic [127:0]      memRdRspData = '0;
  logic [31:0]       memWrData;
  logic              memWrReady = 1'b0, memWrDone = 1'b0, invReady = 1'b0;
  logic [127:0]      invDesc;

  inval_queue_engine #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .headOfs(headOfs), .faultFlag(faultFlag), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdReady(memRdReady), .memRdRspValid(memRdRspValid), .memRdRspData(memRdRspData),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrReady(memWrReady), .memWrDone(memWrDone), .invValid(invValid),
    .invDesc(invDesc), .invReady(invReady), .cplPulse(cplPulse)
  );

  int checks = 0, fails = 0;
  int tailIdx = 0, pushed = 0, consumed = 0, pulses = 0;
  logic [127:0] descMem [QN];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int headIdx();
    return int'(headOfs >> 4);
  endfunction

  function automatic logic [127:0] randDesc();
    int r;
    logic [127:0] d;
    r = int'($urandom % 8);
    d = {$urandom, $urandom, $urandom, $urandom};
    if (r < 5) d[3:0] = 4'(1 + $urandom % 4);
    else begin
      d[3:0]    = 4'd5;
      d[4]      = 1'($urandom % 2);
      d[5]      = (r != 5);
      d[6]      = 1'($urandom % 2);
      d[127:64] = {16'h0, 32'($urandom), 14'($urandom), 2'b00};
    end
    return d;
  endfunction

  task automatic regWrite(input logic [1:0] sel, input logic [63:0] data);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic push(input logic [127:0] d);
    while (((tailIdx + 1) % QN) == headIdx()) @(negedge clk);
    descMem[tailIdx] = d;
    tailIdx = (tailIdx + 1) % QN;
    pushed++;
    regWrite(2'd1, 64'(tailIdx) << 4);
  endtask

  task automatic drain();
    int n = 0;
    while (headIdx() != tailIdx && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(headIdx() == tailIdx, "R3 head reaches tail", 128'(headIdx()), 128'(tailIdx));
  endtask

  // cycle-by-cycle memory responder and reference comparison
  initial begin
    int prevHead, pendWr, cur, t;
    bit fenceBlock, handSeen, wrSeen, prevFault;
    bit rdV [3];
    int rdI [3];
    bit dnV [4];
    logic [127:0] d;
    prevHead = 0; pendWr = 0; fenceBlock = 0; handSeen = 0; wrSeen = 0; prevFault = 0;
    for (int i = 0; i < 3; i++) begin rdV[i] = 0; rdI[i] = 0; end
    for (int i = 0; i < 4; i++) dnV[i] = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      cur = headIdx();
      if (cur != prevHead) begin
        d = descMem[prevHead];
        t = int'(d[3:0]);
        chk(cur == (prevHead + 1) % QN, "R2 head step/wrap", 128'(cur), 128'((prevHead + 1) % QN));
        if (t >= 1 && t <= 4) chk(handSeen, "R4 handoff before head advance", 128'(handSeen), 1);
        if (t == 5 && d[5]) chk(wrSeen, "R7 status write before head advance", 128'(wrSeen), 1);
        if (t == 5 && d[6]) chk(pendWr == 0, "R8 fence waits for all done", 128'(pendWr), 0);
        chk(cplPulse == (t == 5 && d[4]), "R9 completion pulse", 128'(cplPulse), 128'(t == 5 && d[4]));
        if (cplPulse) pulses++;
        consumed++;
        handSeen = 0; wrSeen = 0;
        prevHead = cur;
      end else if (cplPulse) begin
        chk(1'b0, "R9 pulse without head advance", 1, 0);
      end
      if (faultFlag && !prevFault)
        chk(!(descMem[cur][3:0] >= 4'd1 && descMem[cur][3:0] <= 4'd5), "R5 fault only on invalid type",
            128'(descMem[cur][3:0]), 0);
      prevFault = faultFlag;
      if (faultFlag && memRdReq) chk(1'b0, "R5 fetch while faulted", 1, 0);
      // drive responses and readies
      memRdRspValid = rdV[0];
      memRdRspData  = rdV[0] ? descMem[rdI[0]] : '0;
      rdV[0] = rdV[1]; rdI[0] = rdI[1]; rdV[1] = rdV[2]; rdI[1] = rdI[2]; rdV[2] = 0;
      memWrDone = dnV[0];
      dnV[0] = dnV[1]; dnV[1] = dnV[2]; dnV[2] = dnV[3]; dnV[3] = 0;
      memRdReady = ($urandom % 4) != 0;
      invReady   = ($urandom % 3) != 0;
      memWrReady = ($urandom % 4) != 0;
      // handshakes taking effect at the next edge
      if (memRdReq && memRdReady) begin
        chk(memRdAddr == BASE + 48'(cur * 16), "R1 R10 read address", 128'(memRdAddr), 128'(BASE + 48'(cur * 16)));
        chk(!fenceBlock, "R8 fetch during fence", 128'(fenceBlock), 0);
        rdV[2] = 1; rdI[2] = cur;
      end
      if (invValid && invReady) begin
        chk(invDesc == descMem[cur], "R4 handed-off descriptor", invDesc, descMem[cur]);
        handSeen = 1;
      end
      if (memWrValid && memWrReady) begin
        d = descMem[cur];
        chk(d[3:0] == 4'd5 && d[5], "R7 write only for wait with status bit", 128'(d[6:0]), 128'h25);
        chk(memWrAddr == {d[111:66], 2'b00}, "R7 status address", 128'(memWrAddr), 128'({d[111:66], 2'b00}));
        chk(memWrData == d[63:32], "R7 status data", 128'(memWrData), 128'(d[63:32]));
        wrSeen = 1;
        pendWr++;
        if (d[6]) fenceBlock = 1;
        dnV[3] = 1;
      end
      if (memWrDone) begin
        pendWr--;
        if (pendWr == 0) fenceBlock = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad, h;
    logic [127:0] d;
    for (int i = 0; i < QN; i++) descMem[i] = '0;
    repeat (5) @(negedge clk);
    chk(headOfs == 19'h0, "R10 reset head", 128'(headOfs), 0);
    chk(!faultFlag, "R10 reset fault", 128'(faultFlag), 0);
    chk(!memRdReq && !invValid && !memWrValid && !cplPulse, "R10 reset idle",
        128'({memRdReq, invValid, memWrValid, cplPulse}), 0);
    rst_n = 1'b1;
    regWrite(2'd0, {16'h0, BASE} | 64'h0);
    for (int i = 0; i < 4; i++) push(randDesc());
    repeat (30) @(negedge clk);
    chk(headOfs == 19'h0, "R3 no fetch while disabled", 128'(headOfs), 0);
    regWrite(2'd2, 64'h1);
    drain();
    // base/size rewrite while enabled must be ignored
    regWrite(2'd0, 64'h0000_ABCD_E000_0007);
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 40; k++) push(randDesc());
      drain();
    end
    chk(consumed > QN, "R2 ring wrapped at 256 entries", 128'(consumed), 128'(QN + 1));
    // fenced wait with status write followed by a handoff
    d = randDesc(); d[3:0] = 4'd5; d[4] = 1; d[5] = 1; d[6] = 1; push(d);
    d = randDesc(); d[3:0] = 4'd2; push(d);
    drain();
    // invalid types
    for (int v = 0; v < 2; v++) begin
      bad = tailIdx;
      d = randDesc(); d[3:0] = (v == 0) ? 4'd0 : 4'd9; push(d);
      push(randDesc());
      h = 0;
      while (!faultFlag && h < 2000) begin @(negedge clk); h++; end
      chk(faultFlag, "R5 fault raised", 128'(faultFlag), 1);
      chk(headIdx() == bad, "R5 head at offending entry", 128'(headIdx()), 128'(bad));
      repeat (20) @(negedge clk);
      chk(faultFlag && headIdx() == bad, "R6 fault sticky, head held", 128'(headIdx()), 128'(bad));
      regWrite(2'd3, 64'h0);
      chk(faultFlag, "R6 write of zero does not clear", 128'(faultFlag), 1);
      d = randDesc(); d[3:0] = 4'd1; descMem[bad] = d;
      regWrite(2'd3, 64'h1);
      chk(!faultFlag, "R6 write-1 clears fault", 128'(faultFlag), 0);
      drain();
    end
    repeat (10) @(negedge clk);
    chk(consumed == pushed, "R4 every descriptor consumed once", 128'(consumed), 128'(pushed));
    chk(pulses > 0, "R9 completion pulses seen", 128'(pulses), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule